// File: doc/BRIEF.md
# Two-Phase Lockable Timing Generator

The block paces instruction execution with two timing phases, red and green, that take turns and are never high together. Each phase lasts a programmable number of clock cycles, set separately for red and green, so the waveform may be lopsided: for example, a long transfer phase followed by a short recovery phase. An optional idle gap, with both outputs low, can be placed between phases. The outputs feed only a downstream phase sequencer.

Control logic that needs more time than a phase allows can stall the generator in three ways, and red and green stall in the same manner:
- a completion-wait lock holds the phase until a completion input arrives;
- an extension request lengthens the phase by a preset number of cycles;
- a plain lock holds the phase until an unlock strobe.

When a lock is released after the phase time has run out, the next phase starts in the very next cycle. For maintenance there is a manual mode: free-running timing stops, and red or green is chosen by hand with strobes.

Top module: `ptg_timer`

## Requirements
- R1: `red_o` and `green_o` are never high in the same cycle.
- R2: In the cycle after `run_i` is first sampled high, red is asserted. Red then lasts `red_len_i` cycles and green lasts `green_len_i` cycles, alternating. A length of 0 is treated as 1.
- R3: A phase's length is sampled when the phase is entered. A length change made during a phase first affects the next phase of that colour.
- R4: When `gap_len_i` is nonzero at the end of a phase, both outputs stay low for `gap_len_i` cycles before the other phase starts. When it is zero, the other phase follows directly.
- R5: Asynchronous reset, or `run_i` sampled low, forces both outputs low in the following cycle. Operation then restarts with a full-length red phase.
- R6: `req_kind_i` = 2'b01 (completion-wait lock) holds the current phase until `done_i` is sampled high. If the phase time has run out, the other phase starts in the cycle after `done_i`. If `done_i` comes earlier, the phase keeps its normal length.
- R7: `req_kind_i` = 2'b10 (extension) lengthens the current phase by `ext_len_i` cycles. Only the first extension in a phase takes effect.
- R8: `req_kind_i` = 2'b11 (plain lock) holds the current phase until `unlock_i` is sampled high, and `done_i` does not release it. If the phase time has run out, the other phase starts in the next cycle.
- R9: A request is honoured only in a phase whose own qualifier (`req_red_i` for red, `req_green_i` for green) is high and the other qualifier is low. While a lock is held, further requests are ignored. If both qualifiers are high with a nonzero kind, the request is dropped and `conflict_o` is high in the next cycle.
- R10: While `step_mode_i` is high, phase timing is frozen and requests are ignored. A lone `step_red_i` or `step_green_i` selects that phase from the next cycle and holds it. Both strobes together are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Enables phase generation |
| red_len_i | input | LEN_W | Red phase length in cycles |
| green_len_i | input | LEN_W | Green phase length in cycles |
| gap_len_i | input | LEN_W | Idle cycles between phases, 0 for none |
| ext_len_i | input | LEN_W | Extension added by an extension request |
| req_kind_i | input | 2 | Stall request kind: 00 none, 01 wait, 10 extend, 11 plain lock |
| req_red_i | input | 1 | Request qualified by red |
| req_green_i | input | 1 | Request qualified by green |
| done_i | input | 1 | Completion that releases a wait lock |
| unlock_i | input | 1 | Strobe that releases a plain lock |
| step_mode_i | input | 1 | Manual stepping mode |
| step_red_i | input | 1 | Manual red select strobe |
| step_green_i | input | 1 | Manual green select strobe |
| red_o | output | 1 | Red phase active |
| green_o | output | 1 | Green phase active |
| conflict_o | output | 1 | Both qualifiers were raised with a request |

## Verification
A wrong cycle count or length register inside the block shows up as a phase edge that lands early or late. It is exposed on the first boundary after the fault, because the bench predicts every edge of red and green each cycle. A lock state that is stuck or cleared too early shows up as a phase that ends while it should be held, or that outlives its release strobe by a cycle. The bench measures that release-to-next-phase gap directly. A bad qualifier decode shows up as a phase stretched by a request that should have been dropped, or as a missing `conflict_o` pulse one cycle after the request.

// File: rtl/ptg_pkg.sv
package ptg_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_RED    = 3'd1,
    PH_GREEN  = 3'd2,
    PH_GAP_RG = 3'd3,
    PH_GAP_GR = 3'd4
  } phase_e;

  typedef enum logic [1:0] {
    RQ_NONE  = 2'b00,
    RQ_WAIT  = 2'b01,
    RQ_EXT   = 2'b10,
    RQ_PLAIN = 2'b11
  } req_e;

  typedef enum logic [1:0] {
    LK_NONE  = 2'd0,
    LK_WAIT  = 2'd1,
    LK_PLAIN = 2'd2
  } lock_e;

endpackage

// File: rtl/ptg_req_filter.sv
module ptg_req_filter
  import ptg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       step_mode_i,
  input  phase_e     phase_i,
  input  logic       lock_busy_i,
  input  logic       ext_used_i,
  input  logic [1:0] kind_i,
  input  logic       qual_red_i,
  input  logic       qual_green_i,
  output logic       acc_wait_o,
  output logic       acc_ext_o,
  output logic       acc_plain_o,
  output logic       conflict_o
);

  logic match, base, conflict_q;
  req_e kind;

  always_comb begin
    kind  = req_e'(kind_i);
    match = ((phase_i == PH_RED)   && qual_red_i   && !qual_green_i) ||
            ((phase_i == PH_GREEN) && qual_green_i && !qual_red_i);
    base  = run_i && !step_mode_i && match && !lock_busy_i;
    acc_wait_o  = base && (kind == RQ_WAIT);
    acc_plain_o = base && (kind == RQ_PLAIN);
    acc_ext_o   = base && (kind == RQ_EXT) && !ext_used_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) conflict_q <= 1'b0;
    else         conflict_q <= qual_red_i && qual_green_i && (kind != RQ_NONE);
  end

  assign conflict_o = conflict_q;

  AST_CONFLICT_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (qual_red_i && qual_green_i) |-> !(acc_wait_o || acc_ext_o || acc_plain_o)); // R9

endmodule

// File: rtl/ptg_lock_ctrl.sv
module ptg_lock_ctrl
  import ptg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic acc_wait_i,
  input  logic acc_plain_i,
  input  logic done_i,
  input  logic unlock_i,
  output logic busy_o,
  output logic release_o
);

  lock_e lk_q, lk_d;

  always_comb begin
    release_o = (lk_q == LK_NONE) ||
                ((lk_q == LK_WAIT)  && done_i) ||
                ((lk_q == LK_PLAIN) && unlock_i);
    busy_o = (lk_q != LK_NONE);
    lk_d = lk_q;
    if (clear_i)          lk_d = LK_NONE;
    else if (acc_wait_i)  lk_d = LK_WAIT;
    else if (acc_plain_i) lk_d = LK_PLAIN;
    else if (release_o)   lk_d = LK_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lk_q <= LK_NONE;
    else         lk_q <= lk_d;
  end

  AST_WAIT_NEEDS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_q == LK_WAIT && !done_i && !clear_i) |=> busy_o); // R6

  AST_PLAIN_NEEDS_UNLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_q == LK_PLAIN && !unlock_i && !clear_i) |=> busy_o); // R8

endmodule

// File: rtl/ptg_phase_fsm.sv
module ptg_phase_fsm
  import ptg_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             step_mode_i,
  input  logic             step_red_i,
  input  logic             step_green_i,
  input  logic [LEN_W-1:0] red_len_i,
  input  logic [LEN_W-1:0] green_len_i,
  input  logic [LEN_W-1:0] gap_len_i,
  input  logic [LEN_W-1:0] ext_len_i,
  input  logic             acc_ext_i,
  input  logic             new_lock_i,
  input  logic             release_i,
  output phase_e           phase_o,
  output logic             ext_used_o
);

  localparam int TW = LEN_W + 1;

  phase_e          ph_q, ph_d;
  logic [TW-1:0]   cnt_q, cnt_d, tgt_q, tgt_d, tgt_ext;
  logic [TW:0]     cnt_inc;
  logic            ext_q, ext_d;
  logic            elapsed, ends, strobe_ok;

  function automatic logic [TW-1:0] span(input logic [LEN_W-1:0] len);
    span = (len == '0) ? TW'(1) : TW'(len);
  endfunction

  always_comb begin
    tgt_ext   = acc_ext_i ? (tgt_q + TW'(ext_len_i)) : tgt_q;
    cnt_inc   = {1'b0, cnt_q} + (TW+1)'(1);
    elapsed   = cnt_inc >= {1'b0, tgt_ext};
    ends      = elapsed && release_i && !new_lock_i;
    strobe_ok = step_red_i ^ step_green_i;
    ph_d  = ph_q;
    cnt_d = cnt_q;
    tgt_d = tgt_q;
    ext_d = ext_q;
    if (!run_i) begin
      ph_d  = PH_IDLE;
      cnt_d = '0;
      tgt_d = '0;
      ext_d = 1'b0;
    end else if (ph_q == PH_IDLE) begin
      ph_d  = PH_RED;
      cnt_d = '0;
      tgt_d = span(red_len_i);
      ext_d = 1'b0;
    end else if (step_mode_i) begin
      if (strobe_ok) begin
        ph_d  = step_red_i ? PH_RED : PH_GREEN;
        cnt_d = '0;
        tgt_d = span(step_red_i ? red_len_i : green_len_i);
        ext_d = 1'b0;
      end
    end else if (ph_q == PH_RED || ph_q == PH_GREEN) begin
      tgt_d = tgt_ext;
      if (acc_ext_i) ext_d = 1'b1;
      if (ends) begin
        cnt_d = '0;
        ext_d = 1'b0;
        if (gap_len_i != '0) begin
          ph_d  = (ph_q == PH_RED) ? PH_GAP_RG : PH_GAP_GR;
          tgt_d = TW'(gap_len_i);
        end else begin
          ph_d  = (ph_q == PH_RED) ? PH_GREEN : PH_RED;
          tgt_d = span((ph_q == PH_RED) ? green_len_i : red_len_i);
        end
      end else if (!elapsed) begin
        cnt_d = cnt_inc[TW-1:0];
      end
    end else begin
      // idle gap between phases
      if (cnt_inc >= {1'b0, tgt_q}) begin
        ph_d  = (ph_q == PH_GAP_RG) ? PH_GREEN : PH_RED;
        cnt_d = '0;
        tgt_d = span((ph_q == PH_GAP_RG) ? green_len_i : red_len_i);
      end else begin
        cnt_d = cnt_inc[TW-1:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      tgt_q <= '0;
      ext_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      tgt_q <= tgt_d;
      ext_q <= ext_d;
    end
  end

  assign phase_o    = ph_q;
  assign ext_used_o = ext_q;

  AST_TGT_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_RED || ph_q == PH_GREEN) |-> (tgt_q != '0)); // R2

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_RED || ph_q == PH_GREEN) |-> (cnt_q < tgt_q)); // R3

endmodule

// File: rtl/ptg_timer.sv
module ptg_timer
  import ptg_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [LEN_W-1:0] red_len_i,
  input  logic [LEN_W-1:0] green_len_i,
  input  logic [LEN_W-1:0] gap_len_i,
  input  logic [LEN_W-1:0] ext_len_i,
  input  logic [1:0]       req_kind_i,
  input  logic             req_red_i,
  input  logic             req_green_i,
  input  logic             done_i,
  input  logic             unlock_i,
  input  logic             step_mode_i,
  input  logic             step_red_i,
  input  logic             step_green_i,
  output logic             red_o,
  output logic             green_o,
  output logic             conflict_o
);

  phase_e phase;
  logic   ext_used, lk_busy, lk_release;
  logic   acc_wait, acc_ext, acc_plain;

  ptg_req_filter u_filter (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .run_i        (run_i),
    .step_mode_i  (step_mode_i),
    .phase_i      (phase),
    .lock_busy_i  (lk_busy),
    .ext_used_i   (ext_used),
    .kind_i       (req_kind_i),
    .qual_red_i   (req_red_i),
    .qual_green_i (req_green_i),
    .acc_wait_o   (acc_wait),
    .acc_ext_o    (acc_ext),
    .acc_plain_o  (acc_plain),
    .conflict_o   (conflict_o)
  );

  ptg_lock_ctrl u_lock (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (!run_i || step_mode_i),
    .acc_wait_i  (acc_wait),
    .acc_plain_i (acc_plain),
    .done_i      (done_i),
    .unlock_i    (unlock_i),
    .busy_o      (lk_busy),
    .release_o   (lk_release)
  );

  ptg_phase_fsm #(.LEN_W(LEN_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .run_i        (run_i),
    .step_mode_i  (step_mode_i),
    .step_red_i   (step_red_i),
    .step_green_i (step_green_i),
    .red_len_i    (red_len_i),
    .green_len_i  (green_len_i),
    .gap_len_i    (gap_len_i),
    .ext_len_i    (ext_len_i),
    .acc_ext_i    (acc_ext),
    .new_lock_i   (acc_wait || acc_plain),
    .release_i    (lk_release),
    .phase_o      (phase),
    .ext_used_o   (ext_used)
  );

  assign red_o   = (phase == PH_RED);
  assign green_o = (phase == PH_GREEN);

  AST_RUN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (!red_o && !green_o)); // R5

  AST_HELD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !step_mode_i && lk_busy && !lk_release) |=> $stable(phase)); // R6

  AST_STEP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && step_mode_i && !(step_red_i ^ step_green_i) && phase != PH_IDLE)
      |=> $stable(phase)); // R10

  AST_STEP_RED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && step_mode_i && step_red_i && !step_green_i && phase != PH_IDLE)
      |=> red_o); // R10

endmodule

// File: tb/ptg_timer_bench.sv
module ptg_timer_bench;

  localparam int LEN_W = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic run = 1'b0;
  logic [LEN_W-1:0] red_len = 8'd4, green_len = 8'd3, gap_len = 8'd0, ext_len = 8'd4;
  logic [1:0] kind = 2'b00;
  logic qr = 1'b0, qg = 1'b0, done = 1'b0, unlock = 1'b0;
  logic step = 1'b0, sr = 1'b0, sg = 1'b0;
  logic red_o, green_o, conflict_o;

  int checks = 0, fails = 0;
  string cur_tag = "R5";
  bit finished = 1'b0;

  always #4 clk = ~clk;

  ptg_timer #(.LEN_W(LEN_W)) u_ptg_timer (
    .clk_i(clk), .rst_ni(rst_ni), .run_i(run),
    .red_len_i(red_len), .green_len_i(green_len), .gap_len_i(gap_len), .ext_len_i(ext_len),
    .req_kind_i(kind), .req_red_i(qr), .req_green_i(qg), .done_i(done), .unlock_i(unlock),
    .step_mode_i(step), .step_red_i(sr), .step_green_i(sg),
    .red_o(red_o), .green_o(green_o), .conflict_o(conflict_o)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  // behavioural reference: phase 0 idle, 1 red, 2 green, 3 gap to green, 4 gap to red
  int  m_ph = 0, m_cnt = 0, m_tgt = 0, m_lock = 0;
  bit  m_ext = 0, m_conf = 0;

  function automatic int lenof(int v);
    return (v == 0) ? 1 : v;
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    bit match, acc, nl, rel;
    int nt;
    if (!rst_ni) begin
      m_ph = 0; m_cnt = 0; m_tgt = 0; m_lock = 0; m_ext = 0; m_conf = 0;
    end else begin
      m_conf = qr && qg && (kind != 0);
      if (!run) begin
        m_ph = 0; m_cnt = 0; m_tgt = 0; m_lock = 0; m_ext = 0;
      end else if (m_ph == 0) begin
        m_ph = 1; m_cnt = 0; m_tgt = lenof(int'(red_len)); m_lock = 0; m_ext = 0;
      end else if (step) begin
        m_lock = 0;
        if (sr != sg) begin
          m_ph = sr ? 1 : 2; m_cnt = 0; m_ext = 0;
          m_tgt = lenof(int'(sr ? red_len : green_len));
        end
      end else if (m_ph == 1 || m_ph == 2) begin
        match = (m_ph == 1) ? (qr && !qg) : (qg && !qr);
        acc = match && (kind != 0) && (m_lock == 0);
        nt = m_tgt;
        if (acc && kind == 2 && !m_ext) begin nt = nt + int'(ext_len); m_ext = 1; end
        nl = acc && (kind == 1 || kind == 3);
        rel = (m_lock == 0) || (m_lock == 1 && done) || (m_lock == 2 && unlock);
        m_tgt = nt;
        if (nl) m_lock = (kind == 1) ? 1 : 2;
        else if (rel) m_lock = 0;
        if (m_cnt + 1 >= nt && rel && !nl) begin
          m_cnt = 0; m_ext = 0; m_lock = 0;
          if (gap_len != 0) begin
            m_tgt = int'(gap_len); m_ph = (m_ph == 1) ? 3 : 4;
          end else begin
            m_tgt = lenof(int'((m_ph == 1) ? green_len : red_len)); m_ph = (m_ph == 1) ? 2 : 1;
          end
        end else if (m_cnt + 1 < nt) m_cnt++;
      end else begin
        if (m_cnt + 1 >= m_tgt) begin
          m_tgt = lenof(int'((m_ph == 3) ? green_len : red_len));
          m_ph = (m_ph == 3) ? 2 : 1; m_cnt = 0;
        end else m_cnt++;
      end
    end
  end

  // per-cycle comparison and phase run-length monitor
  int red_run = 0, green_run = 0, none_run = 0;
  int last_red = 0, last_green = 0, last_gap = 0;

  always @(negedge clk) begin
    if (!finished) begin
      chk("R1", "overlap", int'(red_o && green_o), 0);
      chk(cur_tag, "red vs model", int'(red_o), int'(m_ph == 1));
      chk(cur_tag, "green vs model", int'(green_o), int'(m_ph == 2));
      chk(cur_tag, "conflict vs model", int'(conflict_o), int'(m_conf));
      if (red_o) red_run++;
      else if (red_run != 0) begin last_red = red_run; red_run = 0; end
      if (green_o) green_run++;
      else if (green_run != 0) begin last_green = green_run; green_run = 0; end
      if (!red_o && !green_o) none_run++;
      else if (none_run != 0) begin last_gap = none_run; none_run = 0; end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wait_enter(bit want_red);
    bit p;
    p = want_red ? red_o : green_o;
    forever begin
      @(negedge clk); #1;
      if ((want_red ? red_o : green_o) && !p) break;
      p = want_red ? red_o : green_o;
    end
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired act=1 exp=0");
    finish_run();
  end

  initial begin
    cyc(3);
    chk("R5", "reset red", int'(red_o), 0);
    chk("R5", "reset green", int'(green_o), 0);
    chk("R5", "reset conflict", int'(conflict_o), 0);
    rst_ni = 1'b1;
    cyc(2);

    cur_tag = "R2";
    run = 1'b1;
    cyc(1);
    chk("R2", "red first after run", int'(red_o), 1);
    wait_enter(0);
    chk("R2", "red length", last_red, 4);
    wait_enter(1);
    chk("R2", "green length", last_green, 3);
    red_len = 8'd0;
    wait_enter(1);
    wait_enter(0);
    chk("R2", "zero length red", last_red, 1);
    red_len = 8'd4;

    cur_tag = "R3";
    wait_enter(1);
    red_len = 8'd6;
    wait_enter(0);
    chk("R3", "mid-phase change not applied", last_red, 4);
    wait_enter(1);
    wait_enter(0);
    chk("R3", "new length applied", last_red, 6);
    red_len = 8'd4;

    cur_tag = "R4";
    gap_len = 8'd2;
    wait_enter(1);
    chk("R4", "gap after green", last_gap, 2);
    wait_enter(0);
    chk("R4", "gap after red", last_gap, 2);
    gap_len = 8'd0;
    wait_enter(1);

    cur_tag = "R5";
    run = 1'b0;
    cyc(1);
    chk("R5", "run low red", int'(red_o), 0);
    chk("R5", "run low green", int'(green_o), 0);
    cyc(3);
    run = 1'b1;
    cyc(1);
    chk("R5", "restart red", int'(red_o), 1);
    wait_enter(0);
    chk("R5", "restart full length", last_red, 4);

    cur_tag = "R6";
    wait_enter(1);
    kind = 2'b01; qr = 1'b1;
    cyc(1);
    kind = 2'b00; qr = 1'b0;
    cyc(8);
    done = 1'b1;
    cyc(1);
    done = 1'b0;
    chk("R6", "green right after done", int'(green_o), 1);
    chk("R6", "held red length", last_red, 10);
    wait_enter(0);
    wait_enter(0);
    kind = 2'b01; qg = 1'b1;
    cyc(1);
    kind = 2'b00; qg = 1'b0; done = 1'b1;
    cyc(1);
    done = 1'b0;
    wait_enter(1);
    chk("R6", "early completion keeps length", last_green, 3);

    cur_tag = "R7";
    wait_enter(0);
    kind = 2'b10; qg = 1'b1;
    cyc(1);
    kind = 2'b00;
    cyc(1);
    kind = 2'b10;
    cyc(1);
    kind = 2'b00; qg = 1'b0;
    wait_enter(1);
    chk("R7", "single extension", last_green, 7);

    cur_tag = "R8";
    wait_enter(0);
    kind = 2'b11; qg = 1'b1;
    cyc(1);
    kind = 2'b00; qg = 1'b0;
    cyc(1);
    done = 1'b1;
    cyc(1);
    done = 1'b0;
    cyc(2);
    unlock = 1'b1;
    cyc(1);
    unlock = 1'b0;
    chk("R8", "red right after unlock", int'(red_o), 1);
    chk("R8", "held green length", last_green, 6);

    cur_tag = "R9";
    wait_enter(1);
    kind = 2'b11; qr = 1'b1; qg = 1'b1;
    cyc(1);
    kind = 2'b00; qr = 1'b0; qg = 1'b0;
    chk("R9", "conflict flagged", int'(conflict_o), 1);
    cyc(1);
    chk("R9", "conflict cleared", int'(conflict_o), 0);
    wait_enter(0);
    chk("R9", "conflicting request dropped", last_red, 4);
    wait_enter(1);
    kind = 2'b11; qg = 1'b1;
    cyc(1);
    kind = 2'b00; qg = 1'b0;
    wait_enter(0);
    chk("R9", "wrong qualifier ignored", last_red, 4);
    wait_enter(1);
    kind = 2'b11; qr = 1'b1;
    cyc(1);
    kind = 2'b01;
    cyc(1);
    kind = 2'b00; qr = 1'b0; unlock = 1'b1;
    cyc(1);
    unlock = 1'b0;
    wait_enter(0);
    chk("R9", "request during lock ignored", last_red, 4);

    cur_tag = "R10";
    wait_enter(0);
    step = 1'b1;
    cyc(6);
    chk("R10", "frozen green", int'(green_o), 1);
    sr = 1'b1;
    cyc(1);
    sr = 1'b0;
    chk("R10", "manual red", int'(red_o), 1);
    cyc(3);
    chk("R10", "manual red held", int'(red_o), 1);
    sr = 1'b1; sg = 1'b1;
    cyc(1);
    sr = 1'b0; sg = 1'b0;
    chk("R10", "both strobes ignored", int'(red_o), 1);
    sg = 1'b1;
    cyc(1);
    sg = 1'b0;
    chk("R10", "manual green", int'(green_o), 1);
    kind = 2'b01; qg = 1'b1;
    cyc(1);
    kind = 2'b00; qg = 1'b0; step = 1'b0;
    wait_enter(1);
    chk("R10", "resume after stepping", last_green, 4);
    cyc(10);

    finish_run();
  end

endmodule